// File: doc/BRIEF.md
# CPU Power-Domain Bring-Up Sequencer

This block is a hardware state machine that powers up one secondary processor core. It works through the core's register-mapped power controller and then takes the core out of reset. A start pulse begins a run, and the core index is sampled on that same cycle. The sequencer then requests a shared-access lock. It issues no bus traffic until the lock is granted, and it keeps the request raised until the run ends.

All register traffic goes over a single-outstanding request/response bus: valid/ready on the request, a write flag, an 8-bit offset, 32-bit data, and a response carrying read data and an error flag. The sequencer first reads the global control word. If the core is already out of reset, the run ends at once. Otherwise it builds up the per-core power word by read-modify-write and polls status bits after each request that needs confirmation. Every poll is bounded by a programmable read budget. The last action writes back the saved global word with the core's reset-release bit set.

A run ends with a one-cycle done pulse and a held status code: 0 success, 1 bus error, 2 poll timeout.

Top module: `core_wake_seq`

## Requirements
- R1: After reset, busy, done, lockReq and busReqValid are low, and status is 0.
- R2: A start while idle raises busy and lockReq on the next cycle. No bus request is issued until lockGrant is seen high.
- R3: The first access reads offset 0x30. If bit (13 + core index) of the returned word is 1, the run ends with status 0 after that single access.
- R4: The second access reads the per-core word at offset 0x34 + 4 × index. Next comes a write of that word with bits 21:20 set. Reads of the same offset then repeat until bits 29:28 of the returned word are both 1.
- R5: A write then sets bits 17:16 on top of the last word read, and reads repeat until bits 25:24 are both 1.
- R6: Two writes follow with no poll between them. The first clears bit 15. The second also clears bits 11:8.
- R7: A write sets bit 1, and reads repeat until bit 5 is 1. A write then sets bit 0, and reads repeat until bit 4 is 1. A single write then clears bit 2. Bits the sequence does not touch keep the value last read.
- R8: The last access writes offset 0x30 with the first-read global word plus bit (13 + index). After that the run ends with status 0. A full run with no failed polls takes exactly 14 accesses.
- R9: A response with the error flag set ends the run at once with status 1. No further access is issued, so the core's reset bit stays clear.
- R10: When pollLimit consecutive reads in one poll fail, the run ends with status 2. A pollLimit of 0 behaves as 1.
- R11: idxWarn goes high when the sampled core index exceeds 1 and holds until the next start. The run still proceeds.
- R12: At most one access is outstanding. A request that is not accepted keeps its offset, write flag and data unchanged.
- R13: lockReq stays high from the cycle after start until the done cycle, and it is low in the done cycle.
- R14: done is high for exactly one cycle per run. busy falls on the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| coreIdx | input | CORE_IDX_W | Core to power up, sampled at start |
| pollLimit | input | TO_W | Maximum reads per poll step |
| lockGrant | input | 1 | Shared-access lock granted |
| lockReq | output | 1 | Shared-access lock requested / held |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | Result: 0 ok, 1 bus error, 2 timeout |
| idxWarn | output | 1 | Sampled index above 1 |
| busReqValid | output | 1 | Bus request valid |
| busReqReady | input | 1 | Bus request accepted |
| busWrite | output | 1 | Request is a write |
| busAddr | output | 8 | Register offset |
| busWdata | output | 32 | Write data |
| busRspValid | input | 1 | Response valid |
| busRspData | input | 32 | Read data |
| busRspErr | input | 1 | Response error flag |

## Verification
The bench uses a responder that reports power status only after a chosen number of reads. This lets it reach both poll exits: success after several failed reads, and the budget running out. A design that counted the budget off by one would show a different access count or a timeout where a success is due. Errors are injected on the first access, on a poll read and on the final release write. A design that kept going after an error would either release the core's reset or make extra accesses. Further runs cover an already-running core, index 2, a zero budget and a stalling ready. Write data is checked position by position, so a wrong bit order in the read-modify-write chain shows up as a miscompare at that access.

// File: rtl/core_wake_pkg.sv
package core_wake_pkg;

  localparam logic [7:0] CTRL_OFS     = 8'h30;
  localparam logic [7:0] PWR_BASE     = 8'h34;
  localparam int         RST_BIT_BASE = 13;

  // per-core word request bits
  localparam logic [31:0] LOGIC_ON_REQ = 32'h0030_0000;
  localparam logic [31:0] LOGIC_OK_REQ = 32'h0003_0000;
  localparam logic [31:0] LOGIC_CLAMP  = 32'h0000_8000;
  localparam logic [31:0] MEM_PD_FIELD = 32'h0000_0F00;
  localparam logic [31:0] MEM_ON_REQ   = 32'h0000_0002;
  localparam logic [31:0] MEM_OK_REQ   = 32'h0000_0001;
  localparam logic [31:0] MEM_CLAMP    = 32'h0000_0004;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BUS_ERR = 2'd1,
    ST_TIMEOUT = 2'd2
  } wakeStatus_e;

  typedef enum logic [1:0] {K_READ, K_WRITE, K_POLL} stepKind_e;

  typedef enum logic [3:0] {
    P_CTRL_RD, P_PWR_RD,
    P_LOGIC_ON_WR, P_LOGIC_ON_POLL,
    P_LOGIC_OK_WR, P_LOGIC_OK_POLL,
    P_CLAMP_WR, P_MEMPD_WR,
    P_MEM_ON_WR, P_MEM_ON_POLL,
    P_MEM_OK_WR, P_MEM_OK_POLL,
    P_MEMCLAMP_WR, P_RELEASE_WR
  } step_e;

  typedef struct packed {
    logic capture;   // latch core index at start
    logic saveCtrl;  // keep global word from response
    logic saveWord;  // keep per-core word from response
    logic commitWr;  // accepted write updates working word
    logic clrPoll;
    logic incPoll;
  } dpCtrl_t;

  function automatic stepKind_e kindOf(step_e s);
    case (s)
      P_CTRL_RD, P_PWR_RD:                                          return K_READ;
      P_LOGIC_ON_POLL, P_LOGIC_OK_POLL, P_MEM_ON_POLL, P_MEM_OK_POLL: return K_POLL;
      default:                                                      return K_WRITE;
    endcase
  endfunction

endpackage

// File: rtl/core_wake_dp.sv
module core_wake_dp
  import core_wake_pkg::*;
#(
  parameter int CORE_IDX_W = 2,
  parameter int TO_W       = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  dpCtrl_t               strobe,
  input  step_e                 step,
  input  logic [CORE_IDX_W-1:0] coreIdxIn,
  input  logic [TO_W-1:0]       pollLimit,
  input  logic [31:0]           rspData,
  output logic [7:0]            reqAddr,
  output logic [31:0]           reqWdata,
  output logic                  pollOk,
  output logic                  alreadyOn,
  output logic                  pollLast,
  output logic                  idxWarn
);

  localparam int CNT_W = TO_W + 1;

  logic [CORE_IDX_W-1:0] idxQ;
  logic [31:0]           ctrlQ;
  logic [31:0]           wordQ;
  logic [TO_W-1:0]       pollCnt;
  logic                  warnQ;
  logic [31:0]           relMask;
  logic [7:0]            pwrAddr;
  logic [CNT_W-1:0]      nextCnt;

  assign relMask = 32'd1 << (RST_BIT_BASE + int'(idxQ));
  assign pwrAddr = PWR_BASE + (8'(idxQ) << 2);

  always_comb begin
    reqAddr = (step == P_CTRL_RD || step == P_RELEASE_WR) ? CTRL_OFS : pwrAddr;
  end

  always_comb begin
    case (step)
      P_LOGIC_ON_WR: reqWdata = wordQ | LOGIC_ON_REQ;
      P_LOGIC_OK_WR: reqWdata = wordQ | LOGIC_OK_REQ;
      P_CLAMP_WR:    reqWdata = wordQ & ~LOGIC_CLAMP;
      P_MEMPD_WR:    reqWdata = wordQ & ~MEM_PD_FIELD;
      P_MEM_ON_WR:   reqWdata = wordQ | MEM_ON_REQ;
      P_MEM_OK_WR:   reqWdata = wordQ | MEM_OK_REQ;
      P_MEMCLAMP_WR: reqWdata = wordQ & ~MEM_CLAMP;
      P_RELEASE_WR:  reqWdata = ctrlQ | relMask;
      default:       reqWdata = wordQ;
    endcase
  end

  always_comb begin
    case (step)
      P_LOGIC_ON_POLL: pollOk = (rspData[29:28] == 2'b11);
      P_LOGIC_OK_POLL: pollOk = (rspData[25:24] == 2'b11);
      P_MEM_ON_POLL:   pollOk = rspData[5];
      P_MEM_OK_POLL:   pollOk = rspData[4];
      default:         pollOk = 1'b0;
    endcase
  end

  assign alreadyOn = |(rspData & relMask);
  assign nextCnt   = CNT_W'(pollCnt) + CNT_W'(1);
  assign pollLast  = (nextCnt >= CNT_W'(pollLimit));
  assign idxWarn   = warnQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxQ    <= '0;
      ctrlQ   <= '0;
      wordQ   <= '0;
      pollCnt <= '0;
      warnQ   <= 1'b0;
    end else begin
      if (strobe.capture) begin
        idxQ  <= coreIdxIn;
        warnQ <= (coreIdxIn > CORE_IDX_W'(1));
      end
      if (strobe.saveCtrl) ctrlQ <= rspData;
      if (strobe.saveWord) wordQ <= rspData;
      else if (strobe.commitWr && step != P_RELEASE_WR) wordQ <= reqWdata;
      if (strobe.clrPoll)      pollCnt <= '0;
      else if (strobe.incPoll) pollCnt <= pollCnt + TO_W'(1);
    end
  end

endmodule

// File: rtl/core_wake_ctrl.sv
module core_wake_ctrl
  import core_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        lockGrant,
  input  logic        busReqReady,
  input  logic        busRspValid,
  input  logic        busRspErr,
  input  logic        pollOk,
  input  logic        alreadyOn,
  input  logic        pollLast,
  output dpCtrl_t     strobe,
  output step_e       step,
  output logic        busReqValid,
  output logic        busWrite,
  output logic        lockReq,
  output logic        busy,
  output logic        done,
  output wakeStatus_e status
);

  typedef enum logic [2:0] {S_IDLE, S_LOCK, S_ISSUE, S_WAIT, S_DONE} state_e;

  state_e      stateQ, stateD;
  step_e       stepQ, stepD;
  wakeStatus_e statusQ, statusD;
  stepKind_e   kind;

  assign kind = kindOf(stepQ);

  always_comb begin
    stateD  = stateQ;
    stepD   = stepQ;
    statusD = statusQ;
    strobe  = '0;
    case (stateQ)
      S_IDLE: if (start) begin
        strobe.capture = 1'b1;
        stepD          = P_CTRL_RD;
        statusD        = ST_OK;
        stateD         = S_LOCK;
      end
      S_LOCK: if (lockGrant) begin
        strobe.clrPoll = 1'b1;
        stateD         = S_ISSUE;
      end
      S_ISSUE: if (busReqReady) begin
        strobe.commitWr = (kind == K_WRITE);
        stateD          = S_WAIT;
      end
      S_WAIT: if (busRspValid) begin
        if (busRspErr) begin
          statusD = ST_BUS_ERR;
          stateD  = S_DONE;
        end else begin
          case (kind)
            K_READ: begin
              strobe.saveCtrl = (stepQ == P_CTRL_RD);
              strobe.saveWord = (stepQ == P_PWR_RD);
              if (stepQ == P_CTRL_RD && alreadyOn) begin
                stateD = S_DONE;
              end else begin
                stepD  = step_e'(stepQ + 4'd1);
                stateD = S_ISSUE;
              end
            end
            K_WRITE: begin
              if (stepQ == P_RELEASE_WR) begin
                stateD = S_DONE;
              end else begin
                stepD          = step_e'(stepQ + 4'd1);
                strobe.clrPoll = 1'b1;
                stateD         = S_ISSUE;
              end
            end
            default: begin
              strobe.saveWord = 1'b1;
              if (pollOk) begin
                stepD          = step_e'(stepQ + 4'd1);
                strobe.clrPoll = 1'b1;
                stateD         = S_ISSUE;
              end else if (pollLast) begin
                statusD = ST_TIMEOUT;
                stateD  = S_DONE;
              end else begin
                strobe.incPoll = 1'b1;
                stateD         = S_ISSUE;
              end
            end
          endcase
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= S_IDLE;
      stepQ   <= P_CTRL_RD;
      statusQ <= ST_OK;
    end else begin
      stateQ  <= stateD;
      stepQ   <= stepD;
      statusQ <= statusD;
    end
  end

  assign step        = stepQ;
  assign status      = statusQ;
  assign busReqValid = (stateQ == S_ISSUE);
  assign busWrite    = (stateQ == S_ISSUE) && (kind == K_WRITE);
  assign lockReq     = (stateQ == S_LOCK) || (stateQ == S_ISSUE) || (stateQ == S_WAIT);
  assign busy        = (stateQ != S_IDLE);
  assign done        = (stateQ == S_DONE);

endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq
  import core_wake_pkg::*;
#(
  parameter int CORE_IDX_W = 2,
  parameter int TO_W       = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [CORE_IDX_W-1:0] coreIdx,
  input  logic [TO_W-1:0]       pollLimit,
  input  logic                  lockGrant,
  output logic                  lockReq,
  output logic                  busy,
  output logic                  done,
  output logic [1:0]            status,
  output logic                  idxWarn,
  output logic                  busReqValid,
  input  logic                  busReqReady,
  output logic                  busWrite,
  output logic [7:0]            busAddr,
  output logic [31:0]           busWdata,
  input  logic                  busRspValid,
  input  logic [31:0]           busRspData,
  input  logic                  busRspErr
);

  dpCtrl_t     strobe;
  step_e       step;
  wakeStatus_e statusE;
  logic        pollOk, alreadyOn, pollLast;

  core_wake_ctrl ctrlI (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .lockGrant   (lockGrant),
    .busReqReady (busReqReady),
    .busRspValid (busRspValid),
    .busRspErr   (busRspErr),
    .pollOk      (pollOk),
    .alreadyOn   (alreadyOn),
    .pollLast    (pollLast),
    .strobe      (strobe),
    .step        (step),
    .busReqValid (busReqValid),
    .busWrite    (busWrite),
    .lockReq     (lockReq),
    .busy        (busy),
    .done        (done),
    .status      (statusE)
  );

  core_wake_dp #(.CORE_IDX_W(CORE_IDX_W), .TO_W(TO_W)) dpI (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .step      (step),
    .coreIdxIn (coreIdx),
    .pollLimit (pollLimit),
    .rspData   (busRspData),
    .reqAddr   (busAddr),
    .reqWdata  (busWdata),
    .pollOk    (pollOk),
    .alreadyOn (alreadyOn),
    .pollLast  (pollLast),
    .idxWarn   (idxWarn)
  );

  assign status = statusE;

endmodule

// File: rtl/core_wake_chk.sv
module core_wake_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [1:0]  status,
  input logic        lockReq,
  input logic        lockGrant,
  input logic        busReqValid,
  input logic        busReqReady,
  input logic        busWrite,
  input logic [7:0]  busAddr,
  input logic [31:0] busWdata,
  input logic        busRspValid,
  input logic        busRspErr
);

  logic pendQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendQ <= 1'b0;
    else if (busReqValid && busReqReady) pendQ <= 1'b1;
    else if (busRspValid) pendQ <= 1'b0;
  end

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busReqValid && !busReqReady |=> busReqValid && $stable(busAddr) && $stable(busWrite) && $stable(busWdata));

  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pendQ |-> !busReqValid);

  a_r2_grant_before_req: assert property (@(posedge clk) disable iff (!rst_n)
    busReqValid |-> lockGrant);

  a_r14_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r14_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  a_r13_lock_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lockReq);

  a_r9_error_status: assert property (@(posedge clk) disable iff (!rst_n)
    busRspValid && busRspErr |=> done && status == 2'd1);

endmodule

bind core_wake_seq core_wake_chk chkI (.*);

// File: tb/core_wake_seq_tb_top.sv
`timescale 1ns/1ps
module core_wake_seq_tb_top;

  localparam int IDX_W = 2;
  localparam int TO_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             start = 1'b0;
  logic [IDX_W-1:0] coreIdx = '0;
  logic [TO_W-1:0]  pollLimit = 16'd4;
  logic             lockGrant;
  logic             lockReq, busy, done, idxWarn;
  logic [1:0]       status;
  logic             busReqValid, busReqReady, busWrite;
  logic [7:0]       busAddr;
  logic [31:0]      busWdata;
  logic             busRspValid, busRspErr;
  logic [31:0]      busRspData;

  core_wake_seq #(.CORE_IDX_W(IDX_W), .TO_W(TO_W)) dut_i (.*);

  // ---------------- environment: lock and responder ----------------
  logic grantHold = 1'b0;
  logic stall = 1'b0;
  logic rdyTog;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin lockGrant <= 1'b0; rdyTog <= 1'b0; end
    else begin lockGrant <= grantHold ? 1'b0 : lockReq; rdyTog <= ~rdyTog; end
  assign busReqReady = stall ? rdyTog : 1'b1;

  logic        loadStb = 1'b0;
  logic [31:0] ldCtrl = '0, ldPwr = '0;
  int          delayV = 0, errAtV = 0, baseCnt = 0;
  logic [31:0] ctrlReg;
  logic [31:0] pwrReg [4];
  int          sinceWr, accCnt, pendViol;
  logic        pend;
  logic        logWr [64];
  logic [7:0]  logAddr [64];
  logic [31:0] logData [64];

  function automatic logic [31:0] overlay(logic [31:0] r, bit ready);
    logic [31:0] o;
    o = r & ~32'h3300_0030;
    if (ready) begin
      o[29:28] = r[21:20];
      o[25:24] = r[17:16];
      o[5]     = r[1];
      o[4]     = r[0];
    end
    return o;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busRspValid <= 1'b0; busRspErr <= 1'b0; busRspData <= '0;
      accCnt <= 0; sinceWr <= 0; pend <= 1'b0; pendViol <= 0;
      ctrlReg <= '0;
      for (int i = 0; i < 4; i++) pwrReg[i] <= '0;
    end else begin : resp
      int n;
      int sel;
      busRspValid <= 1'b0;
      busRspErr   <= 1'b0;
      if (loadStb) begin
        ctrlReg <= ldCtrl;
        for (int i = 0; i < 4; i++) pwrReg[i] <= ldPwr;
      end
      if (busReqValid && pend) pendViol <= pendViol + 1;
      if (busReqValid && busReqReady) begin
        n   = accCnt - baseCnt;
        sel = int'(busAddr - 8'h34) >> 2;
        if (n < 64) begin
          logWr[n] <= busWrite; logAddr[n] <= busAddr; logData[n] <= busWdata;
        end
        accCnt      <= accCnt + 1;
        pend        <= 1'b1;
        busRspValid <= 1'b1;
        busRspData  <= '0;
        if (n + 1 == errAtV) begin
          busRspErr <= 1'b1;
        end else if (busWrite) begin
          if (busAddr == 8'h30) ctrlReg <= busWdata;
          else begin pwrReg[sel & 3] <= busWdata; sinceWr <= 0; end
        end else begin
          if (busAddr == 8'h30) busRspData <= ctrlReg;
          else begin
            busRspData <= overlay(pwrReg[sel & 3], sinceWr >= delayV);
            sinceWr    <= sinceWr + 1;
          end
        end
      end else if (busRspValid) begin
        pend <= 1'b0;
      end
    end
  end

  // ---------------- checking ----------------
  int nChk = 0, nFail = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=0x%08h exp=0x%08h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  idx;
    logic [31:0] ctrlInit;
    logic [31:0] pwrInit;
    logic [7:0]  delay;
    logic [15:0] lim;
    logic [7:0]  errAt;
    logic [1:0]  expStat;
    logic [7:0]  expAcc;
    logic        expWarn;
    logic        expSkip;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h0000_0000, 32'h4000_8F84, 8'd0, 16'd4, 8'd0,  2'd0, 8'd14, 1'b0, 1'b0},
    '{2'd1, 32'h0000_2000, 32'h0000_8F04, 8'd2, 16'd4, 8'd0,  2'd0, 8'd22, 1'b0, 1'b0},
    '{2'd0, 32'h0000_2000, 32'h0000_8F04, 8'd0, 16'd4, 8'd0,  2'd0, 8'd1,  1'b0, 1'b1},
    '{2'd1, 32'h0000_0000, 32'h0000_8F04, 8'd5, 16'd3, 8'd0,  2'd2, 8'd6,  1'b0, 1'b0},
    '{2'd0, 32'h0000_0000, 32'h0000_8F04, 8'd1, 16'd4, 8'd4,  2'd1, 8'd4,  1'b0, 1'b0},
    '{2'd0, 32'h0000_0000, 32'h0000_8F04, 8'd0, 16'd4, 8'd1,  2'd1, 8'd1,  1'b0, 1'b0},
    '{2'd2, 32'h0000_0000, 32'h8000_8F04, 8'd1, 16'd2, 8'd0,  2'd0, 8'd18, 1'b1, 1'b0},
    '{2'd1, 32'h1000_0001, 32'h0000_8F04, 8'd0, 16'd0, 8'd0,  2'd0, 8'd14, 1'b0, 1'b0},
    '{2'd1, 32'h0000_0000, 32'h0000_8F04, 8'd1, 16'd0, 8'd0,  2'd2, 8'd4,  1'b0, 1'b0},
    '{2'd1, 32'h0000_4000, 32'h0000_8F04, 8'd0, 16'd4, 8'd0,  2'd0, 8'd1,  1'b0, 1'b1},
    '{2'd0, 32'h0000_0000, 32'h0000_8F04, 8'd0, 16'd4, 8'd14, 2'd1, 8'd14, 1'b0, 1'b0}
  };

  // write flag per access position of a run with no failed polls (bit i = access i)
  localparam logic [13:0] WR_PAT = 14'b11010111010100;

  logic [1:0]  gotStat;
  logic        gotWarn;
  int          gotAcc;
  bit          timedOut;

  task automatic loadModel(logic [31:0] c, logic [31:0] p, int d, int e, bit s);
    @(negedge clk);
    ldCtrl = c; ldPwr = p; delayV = d; errAtV = e; stall = s; loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    baseCnt = accCnt;
  endtask

  task automatic pulseStart(logic [IDX_W-1:0] idx, logic [TO_W-1:0] lim);
    coreIdx = idx; pollLimit = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int c = 0;
    timedOut = 1'b0;
    while (!done && c < 3000) begin @(negedge clk); c++; end
    if (!done) timedOut = 1'b1;
    gotStat = status; gotWarn = idxWarn; gotAcc = accCnt - baseCnt;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R14 watchdog expired act=0x%08h exp=0x%08h", 32'd1, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !lockReq && !busReqValid && status == 2'd0, "R1 reset outputs",
        {busy, done, lockReq, busReqValid, 26'd0, status}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !busReqValid, "R1 idle after reset", {busy, busReqValid}, 32'd0);

    // R2/R13/R14: lock gating, lock hold, done pulse
    loadModel(32'h0, 32'h0000_8F04, 0, 0, 1'b0);
    grantHold = 1'b1;
    pulseStart(2'd1, 16'd4);
    chk(busy && lockReq, "R2 busy and lockReq after start", {busy, lockReq}, 32'd3);
    repeat (8) @(negedge clk);
    chk(accCnt == baseCnt && !busReqValid && lockReq, "R2 no access without grant",
        accCnt - baseCnt, 32'd0);
    grantHold = 1'b0;
    begin
      int drops = 0;
      int c = 0;
      while (!done && c < 3000) begin
        if (!lockReq) drops++;
        @(negedge clk); c++;
      end
      chk(drops == 0, "R13 lockReq held until done", drops, 32'd0);
    end
    chk(done && !lockReq, "R13 lockReq low in done cycle", {done, lockReq}, 32'd2);
    chk(status == 2'd0, "R8 directed run status", status, 32'd0);
    @(negedge clk);
    chk(!done && !busy, "R14 done single cycle, busy falls", {done, busy}, 32'd0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      logic [31:0] expCtrl, expPwr, relBit;
      string tg;
      t = VECS[v];
      loadModel(t.ctrlInit, t.pwrInit, int'(t.delay), int'(t.errAt), v[0]);
      pulseStart(t.idx, t.lim);
      waitDone();
      tg = $sformatf("v%0d", v);
      chk(!timedOut, {"R14 done seen ", tg}, 32'(timedOut), 32'd0);
      relBit = 32'd1 << (13 + int'(t.idx));
      if (t.expStat == 2'd1)
        chk(gotStat == t.expStat, {"R9 status ", tg}, gotStat, t.expStat);
      else if (t.expStat == 2'd2)
        chk(gotStat == t.expStat, {"R10 status ", tg}, gotStat, t.expStat);
      else
        chk(gotStat == t.expStat, {"R8 status ", tg}, gotStat, t.expStat);
      chk(gotAcc == int'(t.expAcc), {t.expSkip ? "R3" : "R8", " access count ", tg},
          gotAcc, t.expAcc);
      chk(gotWarn == t.expWarn, {"R11 idxWarn ", tg}, gotWarn, t.expWarn);
      expCtrl = (t.expStat == 2'd0 && !t.expSkip) ? (t.ctrlInit | relBit) : t.ctrlInit;
      chk(ctrlReg == expCtrl, {t.expStat == 2'd1 ? "R9" : "R8", " global word ", tg},
          ctrlReg, expCtrl);
      chk(logWr[0] == 1'b0 && logAddr[0] == 8'h30, {"R3 first access read 0x30 ", tg},
          {logWr[0], logAddr[0]}, 32'h30);
      if (t.expStat == 2'd0 && !t.expSkip) begin
        expPwr = (t.pwrInit | 32'h0033_0003) & ~32'h0000_8F04;
        chk((pwrReg[t.idx] & 32'hCCFF_FFCF) == (expPwr & 32'hCCFF_FFCF), {"R7 final core word ", tg},
            pwrReg[t.idx] & 32'hCCFF_FFCF, expPwr & 32'hCCFF_FFCF);
        chk(logAddr[1] == 8'h34 + 8'(4 * int'(t.idx)) && !logWr[1], {"R4 core word offset ", tg},
            logAddr[1], 8'h34 + 8'(4 * int'(t.idx)));
      end
      if (t.expStat == 2'd0 && !t.expSkip && t.delay == 8'd0) begin
        logic [13:0] pat;
        for (int k = 0; k < 14; k++) pat[k] = logWr[k];
        chk(pat == WR_PAT && logAddr[13] == 8'h30, {"R4 access order ", tg}, pat, WR_PAT);
        chk(logData[2][21:20] == 2'b11 && logData[2][17:16] == 2'b00, {"R4 logic-on write ", tg},
            logData[2], 32'h0030_0000);
        chk(logData[4][17:16] == 2'b11, {"R5 power-good write ", tg}, logData[4], 32'h0003_0000);
        chk(!logData[6][15] && logData[6][11:8] == 4'hF, {"R6 clamp write ", tg},
            logData[6] & 32'h8F00, 32'h0F00);
        chk(!logData[7][15] && logData[7][11:8] == 4'h0, {"R6 memory field write ", tg},
            logData[7] & 32'h8F00, 32'h0);
        chk(logData[8][1] && !logData[8][0] && logData[10][0] && logData[12][2:0] == 3'b011,
            {"R7 memory writes ", tg}, {logData[8][3:0], logData[10][3:0], logData[12][3:0]}, 32'h231);
      end
      @(negedge clk);
    end
    stall = 1'b0;

    // R9: no access after error response
    loadModel(32'h0, 32'h0000_8F04, 0, 3, 1'b0);
    pulseStart(2'd0, 16'd4);
    waitDone();
    repeat (5) @(negedge clk);
    chk(accCnt - baseCnt == 3 && !busy, "R9 no access after error", accCnt - baseCnt, 32'd3);

    chk(pendViol == 0, "R12 single outstanding access", pendViol, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule